// File: doc/BRIEF.md
# Vertical pulse overlay generator

This block sits between the base vertical pattern logic of an image-sensor timing generator and its four vertical clock pins. In the one line that carries the sensor-gate pulse, it can add a second, programmable pulse to any of the four vertical signals. Each channel can instead cut a notch into a pulse that is already high. In every other line, the incoming vertical signals pass through with one register of delay.

A pixel-clocked position counter restarts at every rising edge of horizontal sync. Each channel has a start position and a stop position, which shape an internal overlay level. The overlay sits at an idle level until the counter equals the start position. It then flips to its active level and flips back when the counter equals the stop position. A per-channel mode bit chooses how the overlay meets the incoming signal:

- **OR mode:** the overlay idles low and adds a high pulse.
- **AND mode:** the overlay idles high and forces a low window.

A global enable turns the feature off. All settings are held in shadow registers that load at the rising edge of vertical sync, so one frame never mixes old and new values.

Top module: `vpulse_overlay`

## Requirements
- R1: While `rst_n` is low, every bit of `v_out` is 0. After reset, no overlay is applied until a rising edge of `vsync` has loaded an enabled setting and a rising edge of `hsync` has opened a gated line.
- R2: When the loaded enable is 0, `v_out[i]` equals `v_in[i]` of the previous clock for every channel, whatever the other inputs do.
- R3: `sg_line` is sampled on the clock where a rising edge of `hsync` is detected, and it marks the line that follows. In a line where that sample was 0, `v_out` equals the previous clock's `v_in`.
- R4: OR mode is mode bit value 0. In a gated line, the channel's output is 1 while its overlay is active. Otherwise the output follows the delayed input.
- R5: AND mode is mode bit value 1. In a gated line, the channel's output is 0 while its overlay is active. Otherwise the output follows the delayed input.
- R6: Bit i of `cfg_mode` selects the mode of channel i. Bits i*13 to i*13+12 of `cfg_start` and `cfg_stop` hold channel i's positions.
- R7: The overlay of a channel is active in the clock where the counter equals its start position. It stays active in the following clocks until the clock where the counter equals its stop position, which is already inactive. A new line clears it.
- R8: When start and stop positions are equal, the channel's output equals the delayed input for the whole line.
- R9: The counter is 0 in the clock after a rising `hsync` edge is detected. It then rises by one per clock and holds at 8191 until the next rising edge.
- R10: When the stop position is below the start position, the overlay stays active from the start position to the end of the line, including the clocks where the counter holds at 8191.
- R11: Changes on `cfg_enable`, `cfg_mode`, `cfg_start` and `cfg_stop` have no effect until a rising edge of `vsync` is detected. They act from the next clock on.
- R12: Every output has exactly one clock of latency from `v_in` and from the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| vsync | input | 1 | Vertical sync; its rising edge loads the shadow settings |
| sg_line | input | 1 | High when the coming line carries the sensor-gate pulse |
| cfg_enable | input | 1 | Global overlay enable (1 = on) |
| cfg_mode | input | 4 | Per-channel mode, bit i for channel i, 0 = OR, 1 = AND |
| cfg_start | input | 52 | Four 13-bit start positions, channel 0 in the low bits |
| cfg_stop | input | 52 | Four 13-bit stop positions, channel 0 in the low bits |
| v_in | input | 4 | Incoming vertical signals |
| v_out | output | 4 | Vertical signals with the overlay applied, registered |

## Verification
Two events can fall on the same clock:

- a rising `vsync` edge, which loads new positions, modes and the enable into the shadow registers;
- a rising `hsync` edge, which restarts the counter, clears every overlay and samples `sg_line`.

In its random part, the bench drives both syncs high together on a share of line starts. It then judges every following clock against a reference model. That model applies the freshly loaded settings from counter value 0 of the new line and treats the old line's last clock with the old settings. A design that let either edge win over the other would differ in the first clocks of such a line.

// File: rtl/vpo_pkg.sv
// Package: shared sizes for the vertical pulse overlay.
// Assumes: four vertical channels and a 13-bit pixel position counter.
package vpo_pkg;
    localparam int VPO_NUM_CH = 4;
    localparam int VPO_CNT_W  = 13;
endpackage

// File: rtl/vpo_line_counter.sv
// Module: line position counter.
// Detects the rising edge of hsync, restarts a saturating pixel counter
// there and samples the sensor-gate-line flag for the coming line.
// Assumes: hsync and sg_line are synchronous to clk.
module vpo_line_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             sg_line,
    output logic             hs_rise,
    output logic [CNT_W-1:0] cnt,
    output logic             line_on
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hs_d;

    // Rising-edge detect on horizontal sync.
    assign hs_rise = hsync & ~hs_d;

    // Keep previous sync, count pixels, latch the gate flag per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d    <= 1'b0;
            cnt     <= CNT_MAX;
            line_on <= 1'b0;
        end else begin
            hs_d <= hsync;
            if (hs_rise) begin
                cnt     <= '0;
                line_on <= sg_line;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vpo_shadow_regs.sv
// Module: frame-synchronous settings shadow.
// Loads enable, mode bits and all positions at the rising edge of vsync,
// so a frame always runs on one consistent setting.
// Assumes: configuration inputs are static around the vsync edge.
module vpo_shadow_regs #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vsync,
    input  logic                    cfg_enable,
    input  logic [NUM_CH-1:0]       cfg_mode,
    input  logic [NUM_CH*CNT_W-1:0] cfg_start,
    input  logic [NUM_CH*CNT_W-1:0] cfg_stop,
    output logic                    en_sh,
    output logic [NUM_CH-1:0]       mode_sh,
    output logic [NUM_CH*CNT_W-1:0] start_sh,
    output logic [NUM_CH*CNT_W-1:0] stop_sh
);
    logic vs_d;
    logic vs_rise;

    // Rising-edge detect on vertical sync.
    assign vs_rise = vsync & ~vs_d;

    // Capture the live settings once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_d     <= 1'b0;
            en_sh    <= 1'b0;
            mode_sh  <= '0;
            start_sh <= '0;
            stop_sh  <= '0;
        end else begin
            vs_d <= vsync;
            if (vs_rise) begin
                en_sh    <= cfg_enable;
                mode_sh  <= cfg_mode;
                start_sh <= cfg_start;
                stop_sh  <= cfg_stop;
            end
        end
    end
endmodule

// File: rtl/vpo_channel.sv
// Module: one vertical channel slice.
// Builds the overlay level from the position counter and the two
// positions, merges it with the incoming vertical signal by AND or OR,
// and registers the result.
// Assumes: cnt, line_on and hs_rise come from the shared line counter.
module vpo_channel #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic             line_on,
    input  logic             en,
    input  logic             and_mode,
    input  logic [CNT_W-1:0] pos_start,
    input  logic [CNT_W-1:0] pos_stop,
    input  logic             v_in,
    output logic             v_out
);
    logic armed;
    logic at_start;
    logic at_stop;
    logic active;
    logic ovl_lvl;
    logic merged;
    logic nxt;

    // Overlay window: opens at start, closes at stop, stop wins on a tie.
    always_comb begin
        at_start = (cnt == pos_start);
        at_stop  = (cnt == pos_stop);
        active   = (at_start | armed) & ~at_stop;
        ovl_lvl  = active ? ~and_mode : and_mode;
        merged   = and_mode ? (v_in & ovl_lvl) : (v_in | ovl_lvl);
        nxt      = (en & line_on) ? merged : v_in;
    end

    // Hold the window state across the line and register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            v_out <= 1'b0;
        end else begin
            armed <= hs_rise ? 1'b0 : active;
            v_out <= nxt;
        end
    end
endmodule

// File: rtl/vpulse_overlay.sv
// Module: vertical pulse overlay generator (top).
// Adds or cuts a programmable pulse in each vertical channel during the
// sensor-gate line; all other lines pass through with one clock of delay.
// Assumes: all inputs synchronous to clk, reset synchronous active-low.
module vpulse_overlay #(
    parameter int NUM_CH = vpo_pkg::VPO_NUM_CH,
    parameter int CNT_W  = vpo_pkg::VPO_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hsync,
    input  logic                    vsync,
    input  logic                    sg_line,
    input  logic                    cfg_enable,
    input  logic [NUM_CH-1:0]       cfg_mode,
    input  logic [NUM_CH*CNT_W-1:0] cfg_start,
    input  logic [NUM_CH*CNT_W-1:0] cfg_stop,
    input  logic [NUM_CH-1:0]       v_in,
    output logic [NUM_CH-1:0]       v_out
);
    logic                    hs_rise;
    logic [CNT_W-1:0]        cnt;
    logic                    line_on;
    logic                    en_sh;
    logic [NUM_CH-1:0]       mode_sh;
    logic [NUM_CH*CNT_W-1:0] start_sh;
    logic [NUM_CH*CNT_W-1:0] stop_sh;

    vpo_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .sg_line (sg_line),
        .hs_rise (hs_rise),
        .cnt     (cnt),
        .line_on (line_on)
    );

    vpo_shadow_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .cfg_enable (cfg_enable),
        .cfg_mode   (cfg_mode),
        .cfg_start  (cfg_start),
        .cfg_stop   (cfg_stop),
        .en_sh      (en_sh),
        .mode_sh    (mode_sh),
        .start_sh   (start_sh),
        .stop_sh    (stop_sh)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        vpo_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hs_rise   (hs_rise),
            .cnt       (cnt),
            .line_on   (line_on),
            .en        (en_sh),
            .and_mode  (mode_sh[ch]),
            .pos_start (start_sh[ch*CNT_W +: CNT_W]),
            .pos_stop  (stop_sh[ch*CNT_W +: CNT_W]),
            .v_in      (v_in[ch]),
            .v_out     (v_out[ch])
        );
    end
endmodule

// File: rtl/vpo_chk.sv
// Module: property checker for the vertical pulse overlay, bound to the top.
// Assumes: connected to the top's internal counter and shadow signals.
module vpo_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_rise,
    input logic [CNT_W-1:0]  cnt,
    input logic              line_on,
    input logic              en_sh,
    input logic [NUM_CH-1:0] mode_sh,
    input logic [NUM_CH-1:0] v_in,
    input logic [NUM_CH-1:0] v_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2
    passthru_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sh |=> v_out == $past(v_in));

    // R3
    passthru_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_on |=> v_out == $past(v_in));

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> cnt == '0);

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_prop
        // R4
        or_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_sh[ch] && v_in[ch]) |=> v_out[ch]);
        // R5
        and_no_lift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sh[ch] && !v_in[ch]) |=> !v_out[ch]);
    end
endmodule

bind vpulse_overlay vpo_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_rise (hs_rise),
    .cnt     (cnt),
    .line_on (line_on),
    .en_sh   (en_sh),
    .mode_sh (mode_sh),
    .v_in    (v_in),
    .v_out   (v_out)
);

// File: tb/vpulse_overlay_test.sv
module vpulse_overlay_test;
    localparam int NCH = 4;
    localparam int CW  = 13;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0, sg_line = 1'b0, cfg_enable = 1'b0;
    logic [NCH-1:0] cfg_mode = '0;
    logic [NCH*CW-1:0] cfg_start = '0, cfg_stop = '0;
    logic [NCH-1:0] v_in = '0;
    logic [NCH-1:0] v_out;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    vpulse_overlay uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .sg_line(sg_line), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .v_in(v_in), .v_out(v_out)
    );

    // Reference model state, built from the requirements.
    logic m_hsd, m_vsd, m_line, m_en;
    logic [CW-1:0] m_cnt;
    logic [NCH-1:0] m_mode, m_win, m_out;
    logic [NCH*CW-1:0] m_start, m_stop;

    // Expected output bit for one channel (R2-R5).
    function automatic logic exp_bit(logic en, logic line, logic andm,
                                     logic win, logic vin);
        if (!(en && line)) return vin;
        if (andm) return win ? 1'b0 : vin;
        return win ? 1'b1 : vin;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hsd <= 1'b0; m_vsd <= 1'b0; m_line <= 1'b0; m_en <= 1'b0;
            m_cnt <= CMAX; m_mode <= '0; m_win <= '0; m_out <= '0;
            m_start <= '0; m_stop <= '0;
        end else begin
            logic hr, vr;
            hr = hsync && !m_hsd;
            vr = vsync && !m_vsd;
            for (int c = 0; c < NCH; c++) begin
                logic w;
                w = (m_cnt == m_start[c*CW +: CW] || m_win[c]) &&
                    (m_cnt != m_stop[c*CW +: CW]);
                m_out[c] <= exp_bit(m_en, m_line, m_mode[c], w, v_in[c]);
                m_win[c] <= hr ? 1'b0 : w;
            end
            m_hsd <= hsync; m_vsd <= vsync;
            if (hr) begin m_cnt <= '0; m_line <= sg_line; end
            else if (m_cnt != CMAX) m_cnt <= m_cnt + 1'b1;
            if (vr) begin
                m_en <= cfg_enable; m_mode <= cfg_mode;
                m_start <= cfg_start; m_stop <= cfg_stop;
            end
        end
    end

    task automatic check_out();
        checks++;
        if (v_out !== m_out) begin
            fails++;
            $display("FAIL %s: v_out=%b expected=%b at %0t", cur_req, v_out, m_out, $time);
        end
    endtask

    // One clock: check outputs, then drive new inputs.
    task automatic cyc(logic hs, logic vs, logic sg, logic [NCH-1:0] vin);
        @(negedge clk);
        check_out();
        hsync = hs; vsync = vs; sg_line = sg; v_in = vin;
    endtask

    function automatic logic [NCH-1:0] pick_vin(int vm);
        if (vm == 0) return '0;
        if (vm == 1) return '1;
        return NCH'($urandom);
    endfunction

    task automatic run_line(int len, logic sg, int vm, logic vs_too);
        cyc(1'b1, vs_too, sg, pick_vin(vm));
        for (int k = 1; k < len; k++) cyc(1'b0, 1'b0, sg, pick_vin(vm));
    endtask

    task automatic frame_edge();
        cyc(1'b0, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic set_pos(int c, int s, int e);
        cfg_start[c*CW +: CW] = CW'(s);
        cfg_stop[c*CW +: CW]  = CW'(e);
    endtask

    initial begin
        #(150000 * 10);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: outputs low in reset even with inputs high
        v_in = '1;
        repeat (4) @(negedge clk);
        checks++;
        if (v_out !== '0) begin
            fails++;
            $display("FAIL R1: v_out=%b expected=0000", v_out);
        end
        rst_n = 1'b1;
        // R1: no overlay before a vsync loads a setting
        cfg_enable = 1'b1; cfg_mode = 4'b0000;
        for (int c = 0; c < NCH; c++) set_pos(c, 2, 30);
        run_line(40, 1'b1, 0, 1'b0);

        // R2: enable cleared, overlay settings present
        cur_req = "R2";
        cfg_enable = 1'b0;
        frame_edge();
        repeat (3) run_line(50, 1'b1, 2, 1'b0);

        // R4 and R6: OR mode, distinct windows per channel field
        cur_req = "R4";
        cfg_enable = 1'b1; cfg_mode = 4'b0000;
        set_pos(0, 3, 9); set_pos(1, 10, 20); set_pos(2, 0, 1); set_pos(3, 25, 39);
        frame_edge();
        repeat (2) run_line(45, 1'b1, 0, 1'b0);

        // R5: AND mode notches a high input
        cur_req = "R5";
        cfg_mode = 4'b1111;
        frame_edge();
        repeat (2) run_line(45, 1'b1, 1, 1'b0);

        // R6: mixed mode bits per channel
        cur_req = "R6";
        cfg_mode = 4'b0101;
        frame_edge();
        repeat (3) run_line(45, 1'b1, 2, 1'b0);

        // R3: non-gated lines pass through
        cur_req = "R3";
        repeat (3) run_line(45, 1'b0, 2, 1'b0);
        run_line(45, 1'b1, 2, 1'b0);

        // R7: window stays open across clocks, reopens each line
        cur_req = "R7";
        cfg_mode = 4'b1010;
        set_pos(0, 5, 30); set_pos(1, 0, 44); set_pos(2, 12, 13); set_pos(3, 40, 42);
        frame_edge();
        repeat (2) run_line(45, 1'b1, 2, 1'b0);

        // R8: equal positions do nothing
        cur_req = "R8";
        cfg_mode = 4'b0011;
        for (int c = 0; c < NCH; c++) set_pos(c, 7 + c, 7 + c);
        frame_edge();
        run_line(30, 1'b1, 0, 1'b0);
        run_line(30, 1'b1, 1, 1'b0);

        // R10: stop below start keeps window to end of line
        cur_req = "R10";
        cfg_mode = 4'b0110;
        set_pos(0, 20, 4); set_pos(1, 30, 0); set_pos(2, 100, 5); set_pos(3, 10, 9);
        frame_edge();
        repeat (2) run_line(40, 1'b1, 2, 1'b0);

        // R11: live changes ignored until vsync
        cur_req = "R11";
        cfg_mode = 4'b1001; cfg_enable = 1'b0;
        for (int c = 0; c < NCH; c++) set_pos(c, 1, 35);
        repeat (2) run_line(40, 1'b1, 2, 1'b0);
        frame_edge();
        run_line(40, 1'b1, 2, 1'b0);

        // R9: long line, counter saturates at 8191
        cur_req = "R9";
        cfg_enable = 1'b1; cfg_mode = 4'b0010;
        set_pos(0, 8191, 3); set_pos(1, 8180, 8191); set_pos(2, 8190, 8191); set_pos(3, 8000, 8185);
        frame_edge();
        run_line(8260, 1'b1, 2, 1'b0);
        run_line(30, 1'b1, 2, 1'b0);

        // R12: random settings, lines and syncs, incl. vsync with hsync
        cur_req = "R12";
        for (int n = 0; n < 120; n++) begin
            cfg_enable = ($urandom_range(0, 5) != 0);
            cfg_mode = NCH'($urandom);
            for (int c = 0; c < NCH; c++) set_pos(c, $urandom_range(0, 130), $urandom_range(0, 130));
            run_line($urandom_range(20, 140), ($urandom_range(0, 2) != 0),
                     2, ($urandom_range(0, 2) == 0));
        end
        cyc(1'b0, 1'b0, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule